// File: doc/BRIEF.md
# Shadowed Control Register Bank

This block holds the byte-wide control registers of a temperature-compensated current generator. It sits in the window 80h–8Fh behind a serial slave. Registers 0 and 5 are always nonvolatile. Registers 1 and 3 each have a live cell and a stored cell, and a mode bit chosen at runtime decides whether a write reaches the stored cell. Register 6 holds a volatile write-enable latch. Register 7 reflects the thermometer code and cannot be written.

The stored cells are modelled as plain registers that keep their contents across the power-up reset. When a stored cell has been modified, a one-cycle commit pulse follows the next bus STOP, so a bus controller can start its busy timer. Writing some registers reloads the live cells of registers 1 and 3 from their stored copies. The decoded fields drive the current direction, the ADC filter mode, the LUT and DAC bypass selects, the full-scale range, the direct LUT row and the direct DAC byte.

Top module: `shadow_ctl_bank`

## Requirements
- R1: On power-up reset, the live registers 0, 1, 3 and 5 take the values of their stored cells and the write-enable latch clears. The factory stored values are 80h for register 0, 03h for register 5, and 00h for registers 1 and 3.
- R2: The decoded outputs are live wires of the register fields: dirSink = reg0 bit 6, filterOff = reg0 bit 4, dacDirect = reg5 bit 5, lutDirect = reg5 bit 4, fsRange = reg5 bits 1..0, lutRow = live reg1 bits 5..0, dacByte = live reg3.
- R3: The volatility mode is reg0 bit 5. When it is 0, a write to 81h or 83h changes only the live cell. When it is 1, the write changes both the live and the stored cell.
- R4: A write to 81h reloads live reg3 from its stored cell. A write to 83h reloads live reg1 from its stored cell.
- R5: A write to 80h or 85h made while the mode bit (its value before the write) is 0 and wrProt is low reloads live reg1 and reg3 from their stored cells. With wrProt high, no reload happens.
- R6: Reads take effect in the same cycle. 81h and 83h return the stored cells. 80h and 85h return the live values. 86h returns the latch in bit 7 with zeros below it. 87h returns tempCode.
- R7: Writing 80h to 86h sets the write-enable latch. Writing 00h to 86h clears it. Any other value written to 86h leaves it unchanged.
- R8: While the latch is 0, writes to any address other than 86h have no effect.
- R9: nvCommit is high for exactly one cycle, in the cycle after a stopEvt, if a stored cell was written since the previous stopEvt. Otherwise nvCommit stays low.
- R10: Writes to 82h, 84h, 87h, 88h–8Fh and to addresses outside the window are ignored. Reads of those addresses, other than 87h, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset (recalls stored cells) |
| wrEn | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| stopEvt | input | 1 | Bus STOP seen, one cycle |
| wrProt | input | 1 | Write-protect level; suppresses reload on 80h/85h writes |
| tempCode | input | 8 | Thermometer code shown at 87h |
| dirSink | output | 1 | Current direction, 1 = sink |
| filterOff | output | 1 | ADC filtering disabled |
| dacDirect | output | 1 | DAC fed from register 3 |
| lutDirect | output | 1 | LUT row taken from register 1 |
| fsRange | output | 2 | Full-scale range select |
| lutRow | output | 6 | Direct LUT row |
| dacByte | output | 8 | Direct DAC byte |
| weLatch | output | 1 | Write-enable latch |
| nvCommit | output | 1 | Nonvolatile commit pulse |

## Verification
Register writes take effect at the clock edge that samples wrEn. The decoded outputs and rdData are therefore due one edge after the write strobe is driven. rdData is combinational in the address, so a read is valid a moment after the address changes. nvCommit is registered from stopEvt, so it is due one edge after stopEvt and must drop one edge later. The bench drives inputs on the falling edge and samples at the next falling edge, or a short delay after an address change, so each check lands in the cycle where its result is due.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  typedef struct packed {
    logic wr0;
    logic wr1;
    logic wr3;
    logic wr5;
    logic nvWr13;
    logic recall1;
    logic recall3;
  } bankStrobe_t;
endpackage

// File: rtl/bank_ctl.sv
module bank_ctl
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h80,
  parameter logic [7:0] WEL_SET = 8'h80
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              stopEvt,
  input  logic              wrProt,
  input  logic              nvMode,
  output bankStrobe_t       st,
  output logic              inWin,
  output logic [3:0]        off,
  output logic              weLatch,
  output logic              nvCommit
);
  localparam int HI = ADDR_W - 1;

  logic welWr, allowed, nvTouch, dirty, slowRecall;

  assign inWin   = (addr[HI:4] == BASE[HI:4]);
  assign off     = addr[3:0];
  assign welWr   = wrEn && inWin && (off == 4'd6);
  assign allowed = wrEn && inWin && weLatch;

  always_comb begin
    st.wr0 = allowed && (off == 4'd0);
    st.wr1 = allowed && (off == 4'd1);
    st.wr3 = allowed && (off == 4'd3);
    st.wr5 = allowed && (off == 4'd5);
    st.nvWr13 = nvMode && (st.wr1 || st.wr3);
    slowRecall = !nvMode && !wrProt && (st.wr0 || st.wr5);
    st.recall1 = st.wr3 || slowRecall;
    st.recall3 = st.wr1 || slowRecall;
  end

  assign nvTouch = st.wr0 || st.wr5 || st.nvWr13;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLatch  <= 1'b0;
      dirty    <= 1'b0;
      nvCommit <= 1'b0;
    end else begin
      if (welWr && wrData == WEL_SET)    weLatch <= 1'b1;
      else if (welWr && wrData == 8'h00) weLatch <= 1'b0;
      if (stopEvt) begin
        nvCommit <= dirty;
        dirty    <= nvTouch;
      end else begin
        nvCommit <= 1'b0;
        dirty    <= dirty || nvTouch;
      end
    end
  end

  // R7: the set code written to 86h raises the latch
  p_wel_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == BASE + 6 && wrData == WEL_SET) |=> weLatch);

  // R7: the clear code written to 86h drops the latch
  p_wel_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == BASE + 6 && wrData == 8'h00) |=> !weLatch);

  // R8: no register strobe while the latch is clear
  p_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !weLatch) |-> !(st.wr0 || st.wr1 || st.wr3 || st.wr5));

  // R9: a commit pulse only follows a STOP and lasts one cycle
  p_commit_after_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |-> $past(stopEvt));
  p_commit_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |=> !nvCommit);
endmodule

// File: rtl/bank_dp.sv
module bank_dp
  import shadow_bank_pkg::*;
#(
  parameter logic [7:0] INIT0 = 8'h80,
  parameter logic [7:0] INIT1 = 8'h00,
  parameter logic [7:0] INIT3 = 8'h00,
  parameter logic [7:0] INIT5 = 8'h03,
  parameter int ROW_W = 6
)(
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t st,
  input  logic [7:0]  wrData,
  input  logic        inWin,
  input  logic [3:0]  off,
  input  logic        weLatch,
  input  logic [7:0]  tempCode,
  output logic [7:0]  rdData,
  output logic        nvMode,
  output logic        dirSink,
  output logic        filterOff,
  output logic        dacDirect,
  output logic        lutDirect,
  output logic [1:0]  fsRange,
  output logic [ROW_W-1:0] lutRow,
  output logic [7:0]  dacByte
);
  // stored cells keep their contents across the power-up reset
  logic [7:0] nv0 = INIT0;
  logic [7:0] nv1 = INIT1;
  logic [7:0] nv3 = INIT3;
  logic [7:0] nv5 = INIT5;
  logic [7:0] live0, live1, live3, live5;

  always_ff @(posedge clk) begin
    if (rstN) begin
      if (st.wr0)    nv0 <= wrData;
      if (st.wr5)    nv5 <= wrData;
      if (st.wr1 && st.nvWr13) nv1 <= wrData;
      if (st.wr3 && st.nvWr13) nv3 <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live0 <= nv0;
      live1 <= nv1;
      live3 <= nv3;
      live5 <= nv5;
    end else begin
      if (st.wr0) live0 <= wrData;
      if (st.wr5) live5 <= wrData;
      if (st.wr1)          live1 <= wrData;
      else if (st.recall1) live1 <= nv1;
      if (st.wr3)          live3 <= wrData;
      else if (st.recall3) live3 <= nv3;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (inWin) begin
      case (off)
        4'd0: rdData = live0;
        4'd1: rdData = nv1;
        4'd3: rdData = nv3;
        4'd5: rdData = live5;
        4'd6: rdData = {weLatch, 7'b0};
        4'd7: rdData = tempCode;
        default: rdData = 8'h00;
      endcase
    end
  end

  assign nvMode    = live0[5];
  assign dirSink   = live0[6];
  assign filterOff = live0[4];
  assign dacDirect = live5[5];
  assign lutDirect = live5[4];
  assign fsRange   = live5[1:0];
  assign lutRow    = live1[ROW_W-1:0];
  assign dacByte   = live3;

  // R3: a volatile-mode write leaves the stored cell alone
  p_vol_keeps_nv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.wr1 && !nvMode) |=> (nv1 == $past(nv1) && live1 == $past(wrData)));

  // R4: a write to register 3 reloads live register 1
  p_cross_recall_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.wr3 |=> (live1 == $past(nv1)));

  // R4: a write to register 1 reloads live register 3
  p_cross_recall3_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.wr1 |=> (live3 == $past(nv3)));
endmodule

// File: rtl/shadow_ctl_bank.sv
module shadow_ctl_bank
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h80,
  parameter int ROW_W = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              stopEvt,
  input  logic              wrProt,
  input  logic [7:0]        tempCode,
  output logic              dirSink,
  output logic              filterOff,
  output logic              dacDirect,
  output logic              lutDirect,
  output logic [1:0]        fsRange,
  output logic [ROW_W-1:0]  lutRow,
  output logic [7:0]        dacByte,
  output logic              weLatch,
  output logic              nvCommit
);
  bankStrobe_t st;
  logic inWin, nvMode;
  logic [3:0] off;

  bank_ctl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stopEvt(stopEvt), .wrProt(wrProt), .nvMode(nvMode), .st(st),
    .inWin(inWin), .off(off), .weLatch(weLatch), .nvCommit(nvCommit)
  );

  bank_dp #(.ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .inWin(inWin),
    .off(off), .weLatch(weLatch), .tempCode(tempCode), .rdData(rdData),
    .nvMode(nvMode), .dirSink(dirSink), .filterOff(filterOff),
    .dacDirect(dacDirect), .lutDirect(lutDirect), .fsRange(fsRange),
    .lutRow(lutRow), .dacByte(dacByte)
  );
endmodule

// File: tb/sim_shadow_ctl_bank.sv
`timescale 1ns/1ps
module sim_shadow_ctl_bank;
  logic clk = 0, rstN = 0, wrEn = 0, stopEvt = 0, wrProt = 0;
  logic [7:0] addr = 8'h00, wrData = 8'h00, tempCode = 8'h5A;
  logic [7:0] rdData, dacByte;
  logic [5:0] lutRow;
  logic [1:0] fsRange;
  logic dirSink, filterOff, dacDirect, lutDirect, weLatch, nvCommit;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  shadow_ctl_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .stopEvt(stopEvt), .wrProt(wrProt), .tempCode(tempCode),
    .dirSink(dirSink), .filterOff(filterOff), .dacDirect(dacDirect),
    .lutDirect(lutDirect), .fsRange(fsRange), .lutRow(lutRow),
    .dacByte(dacByte), .weLatch(weLatch), .nvCommit(nvCommit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stopEvt = 1;
    @(negedge clk); stopEvt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h80, v); chk("R1 reg0 factory", v, 8'h80);
    rd(8'h85, v); chk("R1 reg5 factory", v, 8'h03);
    rd(8'h86, v); chk("R1 latch clear", v, 8'h00);
    chk("R2 fsRange", {6'b0, fsRange}, 8'h03);
    chk("R2 dirSink", {7'b0, dirSink}, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] v;
    wr(8'h85, 8'h00);
    rd(8'h85, v); chk("R8 locked write", v, 8'h03);
    wr(8'h86, 8'h55);
    chk("R7 other value", {7'b0, weLatch}, 8'h00);
    wr(8'h86, 8'h80);
    rd(8'h86, v); chk("R7 latch set", v, 8'h80);
  endtask

  task automatic t_vol();
    logic [7:0] v;
    wr(8'h81, 8'h2A);
    chk("R3 live reg1", {2'b0, lutRow}, 8'h2A);
    rd(8'h81, v); chk("R6 stored reg1", v, 8'h00);
    wr(8'h83, 8'hC3);
    chk("R3 live reg3", dacByte, 8'hC3);
    chk("R4 reg1 reloaded", {2'b0, lutRow}, 8'h00);
    rd(8'h83, v); chk("R6 stored reg3", v, 8'h00);
    stop_pulse();
    chk("R9 no commit when clean", {7'b0, nvCommit}, 8'h00);
  endtask

  task automatic t_decode();
    wr(8'h81, 8'h11);
    wr(8'h80, 8'hF0);
    chk("R5 reload reg1", {2'b0, lutRow}, 8'h00);
    chk("R5 reload reg3", dacByte, 8'h00);
    chk("R2 dirSink", {7'b0, dirSink}, 8'h01);
    chk("R2 filterOff", {7'b0, filterOff}, 8'h01);
    stop_pulse();
    chk("R9 commit pulse", {7'b0, nvCommit}, 8'h01);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'b0, nvCommit}, 8'h00);
    stop_pulse();
    chk("R9 no second pulse", {7'b0, nvCommit}, 8'h00);
  endtask

  task automatic t_nv();
    logic [7:0] v;
    wr(8'h81, 8'h15);
    rd(8'h81, v); chk("R3 stored reg1", v, 8'h15);
    wr(8'h83, 8'h7E);
    rd(8'h83, v); chk("R3 stored reg3", v, 8'h7E);
    chk("R4 reg1 from stored", {2'b0, lutRow}, 8'h15);
  endtask

  task automatic t_wp();
    wr(8'h80, 8'hC0);
    wr(8'h81, 8'h01);
    chk("R3 volatile live", {2'b0, lutRow}, 8'h01);
    wrProt = 1;
    wr(8'h85, 8'h31);
    chk("R5 protected no reload", {2'b0, lutRow}, 8'h01);
    chk("R2 dacDirect", {7'b0, dacDirect}, 8'h01);
    chk("R2 lutDirect", {7'b0, lutDirect}, 8'h01);
    chk("R2 fsRange", {6'b0, fsRange}, 8'h01);
    wrProt = 0;
    wr(8'h85, 8'h03);
    chk("R5 reload on reg5", {2'b0, lutRow}, 8'h15);
    chk("R5 reload reg3", dacByte, 8'h7E);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(8'h82, 8'hFF);
    rd(8'h82, v); chk("R10 reserved 82h", v, 8'h00);
    wr(8'h8A, 8'hFF);
    rd(8'h8A, v); chk("R10 reserved 8Ah", v, 8'h00);
    wr(8'h87, 8'hFF);
    rd(8'h87, v); chk("R6 status read", v, 8'h5A);
    wr(8'h40, 8'h00);
    rd(8'h80, v); chk("R10 outside window", v, 8'hC0);
    chk("R10 lutRow kept", {2'b0, lutRow}, 8'h15);
  endtask

  task automatic t_powerup();
    logic [7:0] v;
    do_reset();
    rd(8'h80, v); chk("R1 reg0 recalled", v, 8'hC0);
    chk("R1 lutRow recalled", {2'b0, lutRow}, 8'h15);
    chk("R1 dacByte recalled", dacByte, 8'h7E);
    chk("R1 latch cleared", {7'b0, weLatch}, 8'h00);
    wr(8'h86, 8'h80);
    wr(8'h86, 8'h00);
    chk("R7 latch cleared", {7'b0, weLatch}, 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_wel();
    t_vol();
    t_decode();
    t_nv();
    t_wp();
    t_reserved();
    t_powerup();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog act=00 exp=01");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule